// File: doc/BRIEF.md
# Conditional Branch and Stack Unit

This block computes the control flow of an 8-bit processor that has a 16-bit program counter and a 16-bit stack pointer. Both registers live inside the unit. The surrounding datapath offers one opcode together with its two operand bytes, the four flag bits, the B counter register and a 16-bit register pair, and pulses `start`. The unit then works out whether the branch condition holds. It updates PC and SP, returns the decremented counter for the count-and-branch opcode, and moves one 16-bit word over a request/acknowledge memory port when the instruction touches the stack.

Instructions that do not touch the stack complete in one clock. Stack accesses hold `busy` high until the memory acknowledges. After that, PC, SP and any popped pair are committed. A single-cycle `done` pulse marks every completed instruction. A memory word carries its low byte at the lower address.

Top module: `branch_stack_unit`

## Requirements
- R1: While reset is asserted, PC and SP are zero, and `busy`, `done` and `mem_req` are low.
- R2: For conditional jumps, calls and returns, the 3-bit condition field is opcode bits 5:3. Value 0 tests Z clear, 1 tests Z set, 2 tests carry clear, 3 tests carry set, 4 tests PV clear, 5 tests PV set, 6 tests sign clear and 7 tests sign set.
- R3: Opcode 0x18 always branches. Opcodes 001cc000 take their condition from bits 4:3 only, with values 0 to 3 as in R2. A taken relative branch loads PC with PC + 2 + the sign-extended `opnd_lo`, so the reach from the branch opcode is -126 to +129.
- R4: Opcode 0x10 drives `breg_out` = `breg_in` - 1 (mod 256) with a one-cycle `breg_we`. It branches as in R3 only when that new value is non-zero, so B = 1 falls through and B = 0 wraps to 0xFF and branches.
- R5: Opcode 0xC3 always loads PC with {`opnd_hi`,`opnd_lo`}. Opcodes 11ccc010 load that target only when the condition holds.
- R6: When the condition is false, PC advances by 1 for a return, 2 for a relative or counted branch, and 3 for a jump or call. SP is unchanged and no memory request is made.
- R7: A taken call (11ccc100) writes PC + 3 to address SP - 2, sets SP to SP - 2 and loads PC with {`opnd_hi`,`opnd_lo`}.
- R8: A taken return (11ccc000) reads the word at SP into PC and sets SP to SP + 2.
- R9: Push (11rr0101) writes `pair_in` to SP - 2, sets SP to SP - 2 and advances PC by 1.
- R10: Pop (11rr0001) reads the word at SP and presents it on `pair_out`, with `pair_we` high for one cycle and `pair_sel` equal to opcode bits 5:4. It then sets SP to SP + 2 and advances PC by 1.
- R11: From issue until the acknowledge, `busy` and `mem_req` stay high and `mem_addr`, `mem_we` and `mem_wdata` are stable. `start` is ignored during that time. `done` pulses for one cycle after each commit.
- R12: Opcodes outside R3 to R10 leave PC and SP unchanged, raise no `done` and make no memory request.
- R13: PC and SP arithmetic wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Present an instruction for execution |
| opcode | input | 8 | Instruction opcode |
| opnd_lo | input | BYTE_W | First operand byte (displacement or target low) |
| opnd_hi | input | BYTE_W | Second operand byte (target high) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_pv | input | 1 | Parity/overflow flag |
| flag_s | input | 1 | Sign flag |
| breg_in | input | BYTE_W | Current B counter |
| pair_in | input | 2*BYTE_W | Register pair value to push |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 2*BYTE_W | Word read from memory |
| pc | output | 2*BYTE_W | Program counter |
| sp | output | 2*BYTE_W | Stack pointer |
| busy | output | 1 | Stack access in progress |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| breg_out | output | BYTE_W | Decremented B counter |
| breg_we | output | 1 | Write strobe for `breg_out` |
| pair_sel | output | 2 | Register pair named by the last stack opcode |
| pair_out | output | 2*BYTE_W | Popped word |
| pair_we | output | 1 | Write strobe for `pair_out` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 2*BYTE_W | Word address (low byte location) |
| mem_wdata | output | 2*BYTE_W | Word to write |

## Verification
The bench builds the unit with the default BYTE_W of 8, which gives 16-bit PC and SP. At that width the stack pointer wraps on the very first push from reset, and a jump to 0xFFFE followed by a short forward branch carries PC through zero. At 8 bits the extreme displacement of -128 and the counter wrap from 0 to 0xFF are single vector entries. The memory model's acknowledge latency can be varied, which makes a stall of several cycles reachable so that request stability and the rejection of a new `start` can be observed.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_JR, OP_JRCC, OP_DJNZ, OP_JP, OP_JPCC,
    OP_CALL, OP_RET, OP_PUSH, OP_POP
  } ctl_kind_e;

  // Even selector tests a flag clear, odd tests it set; pairs pick Z, C, PV, S.
  function automatic logic cond_met(input logic [2:0] sel, input logic z,
                                    input logic c, input logic pv, input logic s);
    logic flag;
    case (sel[2:1])
      2'd0:    flag = z;
      2'd1:    flag = c;
      2'd2:    flag = pv;
      default: flag = s;
    endcase
    return sel[0] ? flag : ~flag;
  endfunction

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
(
  input  logic [7:0] opcode,
  output ctl_kind_e  kind,
  output logic [2:0] csel,
  output logic [1:0] len
);

  always_comb begin
    kind = OP_NONE;
    csel = opcode[5:3];
    len  = 2'd1;
    casez (opcode)
      8'b0001_1000: begin kind = OP_JR;   len = 2'd2; end
      8'b0001_0000: begin kind = OP_DJNZ; len = 2'd2; end
      8'b001?_?000: begin
        kind = OP_JRCC;
        len  = 2'd2;
        csel = {1'b0, opcode[4:3]};          // R3: only two condition bits
      end
      8'b1100_0011: begin kind = OP_JP;   len = 2'd3; end
      8'b11??_?010: begin kind = OP_JPCC; len = 2'd3; end
      8'b11??_?100: begin kind = OP_CALL; len = 2'd3; end
      8'b11??_?000: begin kind = OP_RET;  len = 2'd1; end
      8'b11??_0101: begin kind = OP_PUSH; len = 2'd1; end
      8'b11??_0001: begin kind = OP_POP;  len = 2'd1; end
      default:      begin kind = OP_NONE; len = 2'd1; end
    endcase
  end

endmodule

// File: rtl/bsu_cond.sv
module bsu_cond
  import bsu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  ctl_kind_e         kind,
  input  logic [2:0]        csel,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_pv,
  input  logic              flag_s,
  input  logic [BYTE_W-1:0] breg_next,
  output logic              taken
);

  logic test_w;
  assign test_w = cond_met(csel, flag_z, flag_c, flag_pv, flag_s);

  always_comb begin
    case (kind)
      OP_JRCC, OP_JPCC, OP_CALL, OP_RET: taken = test_w;
      OP_DJNZ:                           taken = |breg_next;   // R4
      OP_NONE:                           taken = 1'b0;
      default:                           taken = 1'b1;
    endcase
  end

endmodule

// File: rtl/bsu_next.sv
module bsu_next
  import bsu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  ctl_kind_e           kind,
  input  logic                taken,
  input  logic [1:0]          len,
  input  logic [2*BYTE_W-1:0] pc,
  input  logic [2*BYTE_W-1:0] sp,
  input  logic [BYTE_W-1:0]   opnd_lo,
  input  logic [BYTE_W-1:0]   opnd_hi,
  input  logic [2*BYTE_W-1:0] pair_in,
  output logic [2*BYTE_W-1:0] nxt_pc,
  output logic [2*BYTE_W-1:0] nxt_sp,
  output logic                mem_need,
  output logic                mem_write,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [2*BYTE_W-1:0] mem_wdata
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2);

  function automatic logic [WORD_W-1:0] seq_pc(input logic [WORD_W-1:0] p,
                                               input logic [1:0] n);
    return p + WORD_W'(n);
  endfunction

  function automatic logic [WORD_W-1:0] rel_pc(input logic [WORD_W-1:0] p,
                                               input logic [BYTE_W-1:0] d);
    return p + STEP2 + {{BYTE_W{d[BYTE_W-1]}}, d};
  endfunction

  logic [WORD_W-1:0] seq_w, rel_w, abs_w, sp_dn_w, sp_up_w;

  assign seq_w   = seq_pc(pc, len);
  assign rel_w   = rel_pc(pc, opnd_lo);
  assign abs_w   = {opnd_hi, opnd_lo};
  assign sp_dn_w = sp - STEP2;
  assign sp_up_w = sp + STEP2;

  always_comb begin
    nxt_pc    = seq_w;
    nxt_sp    = sp;
    mem_need  = 1'b0;
    mem_write = 1'b0;
    mem_addr  = sp;
    mem_wdata = pair_in;
    case (kind)
      OP_JR, OP_JRCC, OP_DJNZ: if (taken) nxt_pc = rel_w;
      OP_JP, OP_JPCC:          if (taken) nxt_pc = abs_w;
      OP_CALL: if (taken) begin
        nxt_pc    = abs_w;
        nxt_sp    = sp_dn_w;
        mem_need  = 1'b1;
        mem_write = 1'b1;
        mem_addr  = sp_dn_w;
        mem_wdata = seq_w;
      end
      OP_RET: if (taken) begin
        nxt_sp   = sp_up_w;
        mem_need = 1'b1;
      end
      OP_PUSH: begin
        nxt_sp    = sp_dn_w;
        mem_need  = 1'b1;
        mem_write = 1'b1;
        mem_addr  = sp_dn_w;
      end
      OP_POP: begin
        nxt_sp   = sp_up_w;
        mem_need = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/branch_stack_unit.sv
module branch_stack_unit
  import bsu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          opcode,
  input  logic [BYTE_W-1:0]   opnd_lo,
  input  logic [BYTE_W-1:0]   opnd_hi,
  input  logic                flag_z,
  input  logic                flag_c,
  input  logic                flag_pv,
  input  logic                flag_s,
  input  logic [BYTE_W-1:0]   breg_in,
  input  logic [2*BYTE_W-1:0] pair_in,
  input  logic                mem_ack,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic [2*BYTE_W-1:0] pc,
  output logic [2*BYTE_W-1:0] sp,
  output logic                busy,
  output logic                done,
  output logic [BYTE_W-1:0]   breg_out,
  output logic                breg_we,
  output logic [1:0]          pair_sel,
  output logic [2*BYTE_W-1:0] pair_out,
  output logic                pair_we,
  output logic                mem_req,
  output logic                mem_we,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [2*BYTE_W-1:0] mem_wdata
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2);

  typedef enum logic {S_IDLE, S_WAIT} st_e;

  ctl_kind_e         kind_w;
  logic [2:0]        csel_w;
  logic [1:0]        len_w;
  logic              taken_w;
  logic [BYTE_W-1:0] bdec_w;
  logic [WORD_W-1:0] npc_w, nsp_w, maddr_w, mwdata_w;
  logic              mneed_w, mwr_w;

  st_e               st_q;
  logic [WORD_W-1:0] pc_q, sp_q, pend_pc_q, pend_sp_q;
  logic              pend_ldpc_q, pend_ldpair_q;

  // Named internal events
  logic accept_w, issue_w, direct_w, commit_w;

  assign bdec_w   = breg_in - ONE_B;
  assign accept_w = start && (st_q == S_IDLE) && (kind_w != OP_NONE);
  assign issue_w  = accept_w && mneed_w;
  assign direct_w = accept_w && !mneed_w;
  assign commit_w = (st_q == S_WAIT) && mem_ack;

  bsu_decode u_dec (
    .opcode (opcode),
    .kind   (kind_w),
    .csel   (csel_w),
    .len    (len_w)
  );

  bsu_cond #(.BYTE_W(BYTE_W)) u_cond (
    .kind      (kind_w),
    .csel      (csel_w),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_pv   (flag_pv),
    .flag_s    (flag_s),
    .breg_next (bdec_w),
    .taken     (taken_w)
  );

  bsu_next #(.BYTE_W(BYTE_W)) u_next (
    .kind      (kind_w),
    .taken     (taken_w),
    .len       (len_w),
    .pc        (pc_q),
    .sp        (sp_q),
    .opnd_lo   (opnd_lo),
    .opnd_hi   (opnd_hi),
    .pair_in   (pair_in),
    .nxt_pc    (npc_w),
    .nxt_sp    (nsp_w),
    .mem_need  (mneed_w),
    .mem_write (mwr_w),
    .mem_addr  (maddr_w),
    .mem_wdata (mwdata_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      pc_q          <= '0;
      sp_q          <= '0;
      pend_pc_q     <= '0;
      pend_sp_q     <= '0;
      pend_ldpc_q   <= 1'b0;
      pend_ldpair_q <= 1'b0;
      done          <= 1'b0;
      breg_out      <= '0;
      breg_we       <= 1'b0;
      pair_sel      <= '0;
      pair_out      <= '0;
      pair_we       <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
    end else begin
      done    <= 1'b0;
      breg_we <= 1'b0;
      pair_we <= 1'b0;
      if (direct_w) begin
        pc_q     <= npc_w;
        sp_q     <= nsp_w;
        done     <= 1'b1;
        breg_we  <= (kind_w == OP_DJNZ);
        breg_out <= bdec_w;
      end
      if (issue_w) begin
        st_q          <= S_WAIT;
        mem_req       <= 1'b1;
        mem_we        <= mwr_w;
        mem_addr      <= maddr_w;
        mem_wdata     <= mwdata_w;
        pend_pc_q     <= npc_w;
        pend_sp_q     <= nsp_w;
        pend_ldpc_q   <= (kind_w == OP_RET);
        pend_ldpair_q <= (kind_w == OP_POP);
        pair_sel      <= opcode[5:4];
      end
      if (commit_w) begin
        st_q     <= S_IDLE;
        mem_req  <= 1'b0;
        pc_q     <= pend_ldpc_q ? mem_rdata : pend_pc_q;
        sp_q     <= pend_sp_q;
        done     <= 1'b1;
        pair_we  <= pend_ldpair_q;
        pair_out <= mem_rdata;
      end
    end
  end

  assign pc   = pc_q;
  assign sp   = sp_q;
  assign busy = (st_q == S_WAIT);

  AST_RST_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && sp == '0 && !mem_req && !done)); // R1

  AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    direct_w && !taken_w |=> (sp == $past(sp) && !mem_req)); // R6

  AST_DJNZ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    breg_we |-> breg_out == $past(breg_in) - ONE_B); // R4

  AST_SP_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w && mem_we |=> sp == $past(mem_addr)); // R9

  AST_SP_ABOVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w && !mem_we |=> sp == $past(mem_addr) + STEP2); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && busy && $stable(mem_addr)
                            && $stable(mem_wdata) && $stable(mem_we)); // R11

  AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> done && !busy); // R11

endmodule

// File: tb/branch_stack_unit_tb_top.sv
`timescale 1ns/1ps
module branch_stack_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, opnd_lo = '0, opnd_hi = '0, breg_in = '0;
  logic        flag_z = 0, flag_c = 0, flag_pv = 0, flag_s = 0;
  logic [15:0] pair_in = '0;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic [15:0] pc, sp, pair_out, mem_addr, mem_wdata;
  logic        busy, done, breg_we, pair_we, mem_req, mem_we;
  logic [7:0]  breg_out;
  logic [1:0]  pair_sel;

  always #10 clk = ~clk;   // 50 MHz

  branch_stack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .flag_z(flag_z), .flag_c(flag_c),
    .flag_pv(flag_pv), .flag_s(flag_s), .breg_in(breg_in), .pair_in(pair_in),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .busy(busy),
    .done(done), .breg_out(breg_out), .breg_we(breg_we), .pair_sel(pair_sel),
    .pair_out(pair_out), .pair_we(pair_we), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Byte-wide memory model, low byte at lower address
  logic [7:0]  bmem [0:65535];
  logic [7:0]  smem [0:65535];
  logic [15:0] a1;
  int          lat = 0;
  int          wcnt;
  assign a1        = mem_addr + 16'd1;
  assign mem_rdata = {bmem[a1], bmem[mem_addr]};

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        wcnt    <= 0;
        if (mem_we) begin
          bmem[mem_addr] <= mem_wdata[7:0];
          bmem[a1]       <= mem_wdata[15:8];
        end
      end else wcnt <= wcnt + 1;
    end else mem_ack <= 1'b0;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model state
  logic [15:0] m_pc = '0, m_sp = '0;
  logic [15:0] e_pc, e_sp, e_waddr, e_wdata, e_pval;
  logic        e_bwe, e_wr, e_pop;
  logic [7:0]  e_b;
  logic [1:0]  e_psel;
  string       e_tag;

  function automatic bit cc_ok(input logic [2:0] idx, input logic [3:0] f); // f = {s,pv,c,z}
    case (idx)
      3'd0: return !f[0];
      3'd1: return  f[0];
      3'd2: return !f[1];
      3'd3: return  f[1];
      3'd4: return !f[2];
      3'd5: return  f[2];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  task automatic predict(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [3:0] f, input logic [7:0] b, input logic [15:0] pr);
    logic [15:0] nn, rel, s1;
    logic [7:0]  bm1;
    nn  = {hi, lo};
    rel = m_pc + 16'd2 + {{8{lo[7]}}, lo};
    s1  = m_sp + 16'd1;
    e_bwe = 0; e_wr = 0; e_pop = 0; e_b = '0; e_waddr = '0; e_wdata = '0; e_pval = '0;
    e_psel = op[5:4]; e_pc = m_pc; e_sp = m_sp; e_tag = "R12";
    if (op == 8'h18) begin
      e_pc = rel; e_tag = "R3";
    end else if (op == 8'h10) begin
      bm1 = b - 8'd1; e_bwe = 1; e_b = bm1;
      e_pc = (bm1 != 8'd0) ? rel : m_pc + 16'd2; e_tag = "R4";
    end else if ((op & 8'hE7) == 8'h20) begin
      if (cc_ok({1'b0, op[4:3]}, f)) begin e_pc = rel; e_tag = "R2 R3"; end
      else begin e_pc = m_pc + 16'd2; e_tag = "R6"; end
    end else if (op == 8'hC3) begin
      e_pc = nn; e_tag = "R5";
    end else if ((op & 8'hC7) == 8'hC2) begin
      if (cc_ok(op[5:3], f)) begin e_pc = nn; e_tag = "R2 R5"; end
      else begin e_pc = m_pc + 16'd3; e_tag = "R6"; end
    end else if ((op & 8'hC7) == 8'hC4) begin
      if (cc_ok(op[5:3], f)) begin
        e_sp = m_sp - 16'd2; e_wr = 1; e_waddr = e_sp; e_wdata = m_pc + 16'd3;
        e_pc = nn; e_tag = "R2 R7";
      end else begin e_pc = m_pc + 16'd3; e_tag = "R6"; end
    end else if ((op & 8'hC7) == 8'hC0) begin
      if (cc_ok(op[5:3], f)) begin
        e_pc = {smem[s1], smem[m_sp]}; e_sp = m_sp + 16'd2; e_tag = "R2 R8";
      end else begin e_pc = m_pc + 16'd1; e_tag = "R6"; end
    end else if ((op & 8'hCF) == 8'hC5) begin
      e_sp = m_sp - 16'd2; e_wr = 1; e_waddr = e_sp; e_wdata = pr;
      e_pc = m_pc + 16'd1; e_tag = "R9";
    end else if ((op & 8'hCF) == 8'hC1) begin
      e_pop = 1; e_pval = {smem[s1], smem[m_sp]};
      e_sp = m_sp + 16'd2; e_pc = m_pc + 16'd1; e_tag = "R10";
    end
    if (e_wr) begin
      smem[e_waddr]         = e_wdata[7:0];
      smem[e_waddr + 16'd1] = e_wdata[15:8];
    end
  endtask

  task automatic drive(input logic [51:0] v);
    opcode = v[51:44]; opnd_lo = v[43:36]; opnd_hi = v[35:28];
    {flag_s, flag_pv, flag_c, flag_z} = v[27:24];
    breg_in = v[23:16]; pair_in = v[15:0];
  endtask

  task automatic run_one(input logic [51:0] v, input string tag_ovr);
    string t;
    int    n;
    bit    saw_req;
    predict(v[51:44], v[43:36], v[35:28], v[27:24], v[23:16], v[15:0]);
    t = (tag_ovr == "") ? e_tag : tag_ovr;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; saw_req = 0;
    while (!done && n < 50) begin
      saw_req |= mem_req;
      @(negedge clk);
      n++;
    end
    chk({t, " done seen"}, {31'd0, done}, 32'd1);
    chk({t, " pc"}, {16'd0, pc}, {16'd0, e_pc});
    chk({t, " sp"}, {16'd0, sp}, {16'd0, e_sp});
    if (t == "R6") chk("R6 no memory request", {31'd0, saw_req}, 32'd0);
    if (e_bwe) begin
      chk("R4 breg_we", {31'd0, breg_we}, 32'd1);
      chk("R4 breg_out", {24'd0, breg_out}, {24'd0, e_b});
    end
    if (e_wr)
      chk({t, " stored word"}, {16'd0, bmem[e_waddr + 16'd1], bmem[e_waddr]}, {16'd0, e_wdata});
    if (e_pop) begin
      chk("R10 pair_we", {31'd0, pair_we}, 32'd1);
      chk("R10 pair_out", {16'd0, pair_out}, {16'd0, e_pval});
      chk("R10 pair_sel", {30'd0, pair_sel}, {30'd0, e_psel});
    end
    m_pc = e_pc;
    m_sp = e_sp;
  endtask

  // {op, lo, hi, flags{s,pv,c,z}, b, pair}
  localparam int NV = 26;
  localparam logic [51:0] VECS [0:NV-1] = '{
    {8'hC3, 8'h00, 8'h10, 4'h0, 8'h00, 16'h0000},
    {8'h18, 8'h10, 8'h00, 4'h0, 8'h00, 16'h0000},
    {8'h18, 8'h80, 8'h00, 4'h0, 8'h00, 16'h0000},
    {8'h20, 8'h05, 8'h00, 4'h1, 8'h00, 16'h0000},
    {8'h28, 8'h05, 8'h00, 4'h1, 8'h00, 16'h0000},
    {8'h30, 8'h07, 8'h00, 4'h2, 8'h00, 16'h0000},
    {8'h38, 8'hF0, 8'h00, 4'h2, 8'h00, 16'h0000},
    {8'h10, 8'h03, 8'h00, 4'h0, 8'h01, 16'h0000},
    {8'h10, 8'h04, 8'h00, 4'h0, 8'h00, 16'h0000},
    {8'h10, 8'hFE, 8'h00, 4'h0, 8'h05, 16'h0000},
    {8'hC4, 8'h00, 8'h20, 4'h0, 8'h00, 16'h0000},
    {8'hC5, 8'h00, 8'h00, 4'h0, 8'h00, 16'hBEEF},
    {8'hE2, 8'h00, 8'h30, 4'h0, 8'h00, 16'h0000},
    {8'hEA, 8'h00, 8'h40, 4'h0, 8'h00, 16'h0000},
    {8'hF2, 8'h00, 8'h50, 4'h8, 8'h00, 16'h0000},
    {8'hFA, 8'h00, 8'h50, 4'h8, 8'h00, 16'h0000},
    {8'hCC, 8'h11, 8'h22, 4'h0, 8'h00, 16'h0000},
    {8'hD1, 8'h00, 8'h00, 4'h0, 8'h00, 16'h0000},
    {8'hC0, 8'h00, 8'h00, 4'h1, 8'h00, 16'h0000},
    {8'hC8, 8'h00, 8'h00, 4'h1, 8'h00, 16'h0000},
    {8'hD2, 8'h00, 8'h60, 4'h0, 8'h00, 16'h0000},
    {8'hDA, 8'h00, 8'h70, 4'h0, 8'h00, 16'h0000},
    {8'hDC, 8'h34, 8'h12, 4'h2, 8'h00, 16'h0000},
    {8'hF5, 8'h00, 8'h00, 4'h0, 8'h00, 16'h1234},
    {8'hE1, 8'h00, 8'h00, 4'h0, 8'h00, 16'h0000},
    {8'hD8, 8'h00, 8'h00, 4'h2, 8'h00, 16'h0000}
  };

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary_and_end();
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin
      bmem[i] = 8'h00;
      smem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 pc in reset", {16'd0, pc}, 32'd0);
    chk("R1 sp in reset", {16'd0, sp}, 32'd0);
    chk("R1 idle in reset", {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_one(VECS[i], "");

    // R12: opcodes outside the set have no effect
    foreach (VECS[i]) if (i < 3) begin
      @(negedge clk);
      opcode = (i == 0) ? 8'h00 : (i == 1) ? 8'h3E : 8'hCB;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk("R12 no done", {30'd0, done, mem_req}, 32'd0);
        @(negedge clk);
      end
      chk("R12 pc kept", {16'd0, pc}, {16'd0, m_pc});
      chk("R12 sp kept", {16'd0, sp}, {16'd0, m_sp});
    end

    // R11: stalled push, start pulses during busy are ignored
    begin
      int n;
      lat = 3;
      predict(8'hC5, 8'h00, 8'h00, 4'h0, 8'h00, 16'h0A0B);
      @(negedge clk);
      drive({8'hC5, 8'h00, 8'h00, 4'h0, 8'h00, 16'h0A0B});
      start = 1'b1;
      @(negedge clk);
      drive({8'hC3, 8'hFF, 8'h7F, 4'h0, 8'h00, 16'h5555});
      n = 0;
      while (!done && n < 50) begin
        chk("R11 busy held", {30'd0, busy, mem_req}, 32'd3);
        chk("R11 addr stable", {16'd0, mem_addr}, {16'd0, e_waddr});
        @(negedge clk);
        n++;
        if (n == 2) start = 1'b0;
      end
      start = 1'b0;
      chk("R11 stall length", n, 32'd5);
      chk("R11 pc after stall", {16'd0, pc}, {16'd0, e_pc});
      chk("R9 sp after stall", {16'd0, sp}, {16'd0, e_sp});
      chk("R9 stored word", {16'd0, bmem[e_waddr + 16'd1], bmem[e_waddr]}, {16'd0, e_wdata});
      m_pc = e_pc;
      m_sp = e_sp;
      @(negedge clk);
      chk("R11 done single pulse", {31'd0, done}, 32'd0);
      chk("R11 start ignored", {16'd0, pc}, {16'd0, m_pc});
      lat = 0;
    end

    // R13: PC wraps through zero, SP wraps on pop past top
    run_one({8'hC3, 8'hFE, 8'hFF, 4'h0, 8'h00, 16'h0000}, "R13");
    run_one({8'h18, 8'h05, 8'h00, 4'h0, 8'h00, 16'h0000}, "R13");
    run_one({8'hC1, 8'h00, 8'h00, 4'h0, 8'h00, 16'h0000}, "R13");
    run_one({8'hC1, 8'h00, 8'h00, 4'h0, 8'h00, 16'h0000}, "R13");

    summary_and_end();
  end

endmodule